// File: doc/BRIEF.md
# External Data Bus Stretch Sequencer

This block drives the control strobes for a single read or write on an external data-memory bus. A caller raises a start request together with a direction flag, an address, write data and a 3-bit stretch setting. The sequencer then walks a fixed timeline and drives the address latch enable, an active-low chip enable, active-low read and write strobes, the address bus and the data bus with its output enable. It closes with a one-clock completion pulse. On reads it also captures the returned data into a register.

All timing runs on a clock at four times the machine-cycle rate, so one clock is one quarter machine cycle. The stretch setting maps to access lengths of 2, 3, 4 and 5 machine cycles for settings 0 to 3, and 9, 10, 11 and 12 for settings 4 to 7. Three timing bands govern how far the address and chip enable lead the strobe's falling edge and how long the bus is held after it rises. A mode input selects either a shared address/data bus, where the low address byte is presented on the data lines for the address latch, or separate address and data buses.

Top module: `xbus_stretch_seq`

## Requirements
- R1: While reset is high, the outputs are ale_o=0, rd_n_o=1, wr_n_o=1, ce_n_o=1, dq_oe_o=0, done_o=0, addr_o=0 and rdata_q_o=0.
- R2: An access accepted at a clock edge holds ce_n_o low for exactly 4*N clocks after that edge. N is 2, 3, 4, 5, 9, 10, 11 or 12 for stretch_i values 0 through 7.
- R3: Counting clocks from the accept edge (clock 0 is the first clock of the access), the strobe first goes low in clock 1 for stretch 0, clock 2 for stretch 1 to 3, and clock 5 for stretch 4 to 7.
- R4: The strobe is wr_n_o when write_i=1 and rd_n_o when write_i=0; the other strobe stays high. The strobe returns high 1 clock before the end of the access for stretch 0 to 3, and 4 clocks before the end for stretch 4 to 7.
- R5: A strobe is low only while ce_n_o is low. addr_o carries the full accepted address from clock 0 of the access onward.
- R6: ale_o is high in clock 0 of every access and low in its other clocks. With mux_mode_i=1, dq_o carries addr[DATA_W-1:0] with dq_oe_o=1 in every clock before the strobe falls. With mux_mode_i=0, dq_oe_o is 0 in those clocks.
- R7: On a write, dq_o carries the write data with dq_oe_o=1 from the strobe's falling clock to the last clock of the access. On a read, dq_oe_o is 0 from the strobe's falling clock on.
- R8: On a read, rdata_q_o takes the value rdata_i had in the last clock with rd_n_o low. It shows that value from the clock in which rd_n_o rises and holds it afterwards.
- R9: done_o is high for exactly one clock, the clock right after the access's last clock, and is low at every other time.
- R10: A start request while an access is in progress is ignored. Changes to the other inputs during an access have no effect on its length, address or strobes.
- R11: While idle with ale_quiet_i=0, ale_o is high for one clock in every four. While idle with ale_quiet_i=1, ale_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-machine-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one access (taken only when idle) |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| stretch_i | input | 3 | Stretch setting 0 to 7 |
| ale_quiet_i | input | 1 | 1 = keep the address latch enable still while idle |
| mux_mode_i | input | 1 | 1 = shared address/data bus, 0 = separate buses |
| rdata_i | input | DATA_W | Data returned by memory |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ce_n_o | output | 1 | Chip enable, active low |
| addr_o | output | ADDR_W | Address bus |
| dq_o | output | DATA_W | Data bus output value |
| dq_oe_o | output | 1 | Data bus output enable |
| rdata_q_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
A phase counter that is off by one shows directly at the ports. It moves the strobe edge or the chip-enable release by a clock within the same access, and it moves the completion pulse off the clock that follows chip-enable release. A band decode error shows as a strobe fall at the wrong clock from the access start, or as write data dropped early. Either one appears within at most 48 clocks of the start request. A capture placed at the wrong tick shows as soon as the read finishes, because the bench presents the correct read value only in the last strobe-low clock.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int QPC     = 4;
  localparam int MAX_CYC = 12;
  localparam int TW      = $clog2(QPC * MAX_CYC);

  typedef enum logic [1:0] {
    BAND_ZERO,
    BAND_LOW,
    BAND_HIGH
  } band_e;

  typedef struct packed {
    logic [TW-1:0] last;
    logic [TW-1:0] lead;
    logic [TW-1:0] rise;
  } timing_t;
endpackage

// File: rtl/xbus_timing_decode.sv
module xbus_timing_decode
  import xbus_pkg::*;
#(
  parameter int ST_W = 3
) (
  input  logic [ST_W-1:0] stretch,
  output timing_t         tim
);
  localparam int LOW_BASE  = 2;
  localparam int HIGH_BASE = 5;

  band_e         band;
  logic [TW-1:0] cyc;
  logic [TW-1:0] quarters;
  logic [TW-1:0] hold;

  always_comb begin
    if (stretch == '0)             band = BAND_ZERO;
    else if (!stretch[ST_W-1])     band = BAND_LOW;
    else                           band = BAND_HIGH;

    // break at the top bit: the upper half of settings adds three cycles
    cyc = TW'(stretch) + (stretch[ST_W-1] ? TW'(HIGH_BASE) : TW'(LOW_BASE));
    quarters = TW'(cyc * TW'(QPC));

    unique case (band)
      BAND_ZERO: begin tim.lead = TW'(1); hold = TW'(1); end
      BAND_LOW:  begin tim.lead = TW'(2); hold = TW'(1); end
      default:   begin tim.lead = TW'(5); hold = TW'(4); end
    endcase
    tim.last = quarters - TW'(1);
    tim.rise = quarters - hold;
  end
endmodule

// File: rtl/xbus_phase_gen.sv
module xbus_phase_gen #(
  parameter int QPC = 4
) (
  input  logic clk,
  input  logic rst,
  output logic wrap
);
  localparam int PW = (QPC > 1) ? $clog2(QPC) : 1;

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst)                       ph <= '0;
    else if (ph == PW'(QPC - 1))   ph <= '0;
    else                           ph <= ph + PW'(1);
  end

  assign wrap = (ph == PW'(QPC - 1));

  assert_phase_range_R11: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (ph == '0));
endmodule

// File: rtl/xbus_strobe_decode.sv
module xbus_strobe_decode
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              active,
  input  logic [TW-1:0]     t,
  input  timing_t           tim,
  input  logic              is_wr,
  input  logic              mux,
  input  logic              quiet,
  input  logic              idle_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ce_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq
);
  logic [DATA_W-1:0] addr_lo;
  logic              in_lead;
  logic              strobe_on;

  generate
    if (DATA_W <= ADDR_W) begin : g_narrow
      assign addr_lo = addr[DATA_W-1:0];
    end else begin : g_wide
      assign addr_lo = {{(DATA_W-ADDR_W){1'b0}}, addr};
    end
  endgenerate

  always_comb begin
    in_lead   = (t < tim.lead);
    strobe_on = !in_lead && (t < tim.rise);
    ale   = !quiet && idle_tick;
    rd_n  = 1'b1;
    wr_n  = 1'b1;
    ce_n  = 1'b1;
    dq_oe = 1'b0;
    dq    = '0;
    if (active) begin
      ale  = (t == '0);
      ce_n = 1'b0;
      rd_n = !(strobe_on && !is_wr);
      wr_n = !(strobe_on && is_wr);
      if (mux && in_lead) begin
        dq    = addr_lo;
        dq_oe = 1'b1;
      end else if (is_wr && !in_lead) begin
        dq    = wdata;
        dq_oe = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbus_stretch_seq.sv
module xbus_stretch_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [2:0]        stretch_i,
  input  logic              ale_quiet_i,
  input  logic              mux_mode_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              ce_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_q_o,
  output logic              done_o
);
  timing_t tim_in, tim_q, tim_n;
  logic              busy_q, busy_n;
  logic [TW-1:0]     t_q, t_n;
  logic              is_wr_q, is_wr_n;
  logic              mux_q, mux_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic              accept, at_end, capture;
  logic              idle_tick;
  logic              d_ale, d_rd_n, d_wr_n, d_ce_n, d_oe;
  logic [DATA_W-1:0] d_dq;

  xbus_timing_decode #(.ST_W(3)) u_timing (
    .stretch (stretch_i),
    .tim     (tim_in)
  );

  xbus_phase_gen #(.QPC(QPC)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .wrap (idle_tick)
  );

  always_comb begin
    accept  = !busy_q && start_i;
    at_end  = busy_q && (t_q == tim_q.last);
    capture = busy_q && !is_wr_q && (t_q == tim_q.rise - TW'(1));
    busy_n  = busy_q;
    t_n     = t_q;
    if (busy_q) begin
      if (at_end) begin
        busy_n = 1'b0;
        t_n    = '0;
      end else begin
        t_n = t_q + TW'(1);
      end
    end else if (start_i) begin
      busy_n = 1'b1;
      t_n    = '0;
    end
    is_wr_n = accept ? write_i    : is_wr_q;
    mux_n   = accept ? mux_mode_i : mux_q;
    addr_n  = accept ? addr_i     : addr_q;
    wdata_n = accept ? wdata_i    : wdata_q;
    tim_n   = accept ? tim_in     : tim_q;
  end

  xbus_strobe_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .active    (busy_n),
    .t         (t_n),
    .tim       (tim_n),
    .is_wr     (is_wr_n),
    .mux       (mux_n),
    .quiet     (ale_quiet_i),
    .idle_tick (idle_tick),
    .addr      (addr_n),
    .wdata     (wdata_n),
    .ale       (d_ale),
    .rd_n      (d_rd_n),
    .wr_n      (d_wr_n),
    .ce_n      (d_ce_n),
    .dq_oe     (d_oe),
    .dq        (d_dq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      t_q       <= '0;
      is_wr_q   <= 1'b0;
      mux_q     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      tim_q     <= '0;
      ale_o     <= 1'b0;
      rd_n_o    <= 1'b1;
      wr_n_o    <= 1'b1;
      ce_n_o    <= 1'b1;
      addr_o    <= '0;
      dq_o      <= '0;
      dq_oe_o   <= 1'b0;
      rdata_q_o <= '0;
      done_o    <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      t_q     <= t_n;
      is_wr_q <= is_wr_n;
      mux_q   <= mux_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      tim_q   <= tim_n;
      ale_o   <= d_ale;
      rd_n_o  <= d_rd_n;
      wr_n_o  <= d_wr_n;
      ce_n_o  <= d_ce_n;
      addr_o  <= addr_n;
      dq_o    <= d_dq;
      dq_oe_o <= d_oe;
      done_o  <= at_end;
      if (capture) rdata_q_o <= rdata_i;
    end
  end

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_o && !wr_n_o));

  assert_strobe_inside_ce_R5: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_o || !wr_n_o) |-> !ce_n_o);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_after_ce_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ce_n_o);

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (!ce_n_o && start_i) |=> $stable(addr_o));

  assert_window_order_R3: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (tim_q.lead < tim_q.rise));
endmodule

// File: tb/xbus_stretch_seq_tb.sv
module xbus_stretch_seq_tb;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int NV = 10;

  // {write, mux, stretch[2:0], addr[15:0], wdata[7:0], rdata[7:0]}
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd0, 16'h1234, 8'h00, 8'hA5},
    {1'b1, 1'b1, 3'd0, 16'h2345, 8'h3C, 8'h00},
    {1'b0, 1'b0, 3'd1, 16'h3456, 8'h00, 8'h5A},
    {1'b1, 1'b0, 3'd2, 16'h4567, 8'hC3, 8'h00},
    {1'b0, 1'b1, 3'd3, 16'h5678, 8'h00, 8'h96},
    {1'b1, 1'b1, 3'd4, 16'h6789, 8'h69, 8'h00},
    {1'b0, 1'b0, 3'd5, 16'h789A, 8'h00, 8'h0F},
    {1'b1, 1'b0, 3'd6, 16'h89AB, 8'hF0, 8'h00},
    {1'b0, 1'b1, 3'd7, 16'h9ABC, 8'h00, 8'h81},
    {1'b1, 1'b1, 3'd7, 16'hABCD, 8'h7E, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i, write_i, ale_quiet_i, mux_mode_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i, rdata_i;
  logic [2:0]    stretch_i;
  logic          ale_o, rd_n_o, wr_n_o, ce_n_o, dq_oe_o, done_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] dq_o, rdata_q_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  always #4 clk = ~clk;

  xbus_stretch_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .write_i(write_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .stretch_i(stretch_i),
    .ale_quiet_i(ale_quiet_i), .mux_mode_i(mux_mode_i), .rdata_i(rdata_i),
    .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .ce_n_o(ce_n_o),
    .addr_o(addr_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .rdata_q_o(rdata_q_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt == 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int ex_quarters(input int s);
    return 4 * ((s < 4) ? (2 + s) : (5 + s));
  endfunction
  function automatic int ex_lead(input int s);
    return (s == 0) ? 1 : ((s < 4) ? 2 : 5);
  endfunction
  function automatic int ex_hold(input int s);
    return (s < 4) ? 1 : 4;
  endfunction

  task automatic run_access(input logic wr, input logic mux, input int st,
                            input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                            input logic [DW-1:0] rd, input logic quiet);
    int q, lead, rise;
    int ce_low, first_s, last_s, other_low, done_at, done_cnt, ale_bad;
    logic [DW-1:0] dq0, dq_lead;
    logic oe0, oe_lead, oe_last, addr_ok;
    q = ex_quarters(st);
    lead = ex_lead(st);
    rise = q - ex_hold(st);
    ce_low = 0; first_s = -1; last_s = -1; other_low = 0;
    done_at = -1; done_cnt = 0; ale_bad = 0; addr_ok = 1'b1;
    dq0 = '0; dq_lead = '0; oe0 = 1'b0; oe_lead = 1'b0; oe_last = 1'b0;
    @(negedge clk);
    start_i = 1'b1; write_i = wr; mux_mode_i = mux; stretch_i = 3'(st);
    addr_i = ad; wdata_i = wd; ale_quiet_i = quiet; rdata_i = ~rd;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= q; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 2) begin
        addr_i = ~ad; stretch_i = ~stretch_i; write_i = ~wr;
      end
      rdata_i = (k == rise - 1) ? rd : ~rd;
      if (!ce_n_o) ce_low++;
      if (k < q) begin
        if ((wr ? wr_n_o : rd_n_o) == 1'b0) begin
          if (first_s < 0) first_s = k;
          last_s = k;
        end
        if ((wr ? rd_n_o : wr_n_o) == 1'b0) other_low++;
        if (ale_o !== (k == 0)) ale_bad++;
        if (addr_o !== ad) addr_ok = 1'b0;
      end
      if (done_o) begin done_cnt++; done_at = k; end
      if (k == 0)        begin dq0 = dq_o; oe0 = dq_oe_o; end
      if (k == lead)     begin dq_lead = dq_o; oe_lead = dq_oe_o; end
      if (k == q - 1)    oe_last = dq_oe_o;
    end
    chk("R2 ce low length", 32'(ce_low), 32'(q));
    chk("R3 strobe fall clock", 32'(first_s), 32'(lead));
    chk("R4 strobe rise clock", 32'(last_s), 32'(rise - 1));
    chk("R4 other strobe idle", 32'(other_low), 32'd0);
    chk("R5 address held", 32'(addr_ok), 32'd1);
    chk("R6 ale only clock 0", 32'(ale_bad), 32'd0);
    chk("R6 mux address phase oe", 32'(oe0), 32'(mux));
    if (mux) chk("R6 mux address byte", 32'(dq0), 32'(ad[DW-1:0]));
    if (wr) begin
      chk("R7 write data", 32'(dq_lead), 32'(wd));
      chk("R7 write oe at fall", 32'(oe_lead), 32'd1);
      chk("R7 write oe at end", 32'(oe_last), 32'd1);
    end else begin
      chk("R7 read oe off", 32'(oe_lead), 32'd0);
      chk("R8 captured read data", 32'(rdata_q_o), 32'(rd));
    end
    chk("R9 done clock", 32'(done_at), 32'(q));
    chk("R9 done count", 32'(done_cnt), 32'd1);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; write_i = 1'b0; ale_quiet_i = 1'b1;
    mux_mode_i = 1'b0; addr_i = '0; wdata_i = '0; rdata_i = '0; stretch_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ale", 32'(ale_o), 32'd0);
    chk("R1 rd_n", 32'(rd_n_o), 32'd1);
    chk("R1 wr_n", 32'(wr_n_o), 32'd1);
    chk("R1 ce_n", 32'(ce_n_o), 32'd1);
    chk("R1 oe", 32'(dq_oe_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 addr", 32'(addr_o), 32'd0);
    chk("R1 rdata", 32'(rdata_q_o), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_access(VEC[v][36], VEC[v][35], int'(VEC[v][34:32]), VEC[v][31:16],
                 VEC[v][15:8], VEC[v][7:0], 1'(v % 2));
      @(negedge clk);
      chk("R8 read data held", 32'(rdata_q_o),
          32'(VEC[v][36] ? rdata_q_o : VEC[v][7:0]));
    end

    // R10: start during an access is ignored
    begin
      int ce_low, extra_low;
      ce_low = 0; extra_low = 0;
      @(negedge clk);
      start_i = 1'b1; write_i = 1'b0; mux_mode_i = 1'b0; stretch_i = 3'd1;
      addr_i = 16'h0F0F; ale_quiet_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k <= 12; k++) begin
        if (k > 0) @(negedge clk);
        if (k == 3) begin start_i = 1'b1; addr_i = 16'hF0F0; stretch_i = 3'd7; end
        if (k == 10) start_i = 1'b0;
        if (!ce_n_o) ce_low++;
      end
      chk("R10 length unchanged", 32'(ce_low), 32'd12);
      chk("R10 address unchanged", 32'(addr_o), 32'h0F0F);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!ce_n_o) extra_low++;
      end
      chk("R10 no second access", 32'(extra_low), 32'd0);
    end

    // R11 idle address latch enable
    begin
      int hi;
      ale_quiet_i = 1'b0;
      @(negedge clk);
      hi = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (ale_o) hi++;
      end
      chk("R11 idle ale toggles", 32'(hi), 32'd2);
      ale_quiet_i = 1'b1;
      @(negedge clk);
      hi = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (ale_o) hi++;
      end
      chk("R11 idle ale quiet", 32'(hi), 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule